// File: doc/BRIEF.md
# Flat Register Window to Port and Indexed-Register Bridge

This block sits on the slave side of a 4 KiB memory-mapped register window of a display controller. It decodes each host access by its offset and turns it into cycles on one of two back-ends. The first back-end is a legacy 8-bit port bus. Byte lanes that fall in the port sub-window go to it one byte at a time, at the matching port address. The second back-end is a register file that can only be reached through an index/data pair. The bridge exposes that register file as a flat array of 16-bit registers. For every halfword it touches, it first writes the register index and then performs the data read or data write.

The host presents a word address, a write flag, 32 bits of write data and four byte strobes, and holds them with `req_valid` until the bridge raises `req_ready`. Wide accesses are split into native-width beats, lowest byte lane first. Read data is gathered into the matching lanes and returned in the cycle `req_ready` is high. Offsets that map to neither back-end, and every access made while the window is disabled, finish at once without touching either back-end.

Top module: `mmio_idx_bridge`

## Requirements
- R1: While reset is held and right after it, `req_ready`, `pt_req` and `rf_req` are low and `rsp_rdata` is zero.
- R2: Byte offsets 0x000–0x3FF, 0x420–0x4FF and 0x518–0xFFF reach neither back-end. A read there returns zero, a write is dropped, and `req_ready` rises in the cycle after `req_valid` is first seen.
- R3: While `win_en` is low when an access is accepted, that access behaves as in R2 at every offset.
- R4: A strobed lane L of the word at byte offset A (0x400 ≤ A ≤ 0x41C) produces one port cycle at port address 0x3C0 + (A − 0x400) + L. Its write byte comes from data bits [8L+7:8L], and its read byte returns in the same bits.
- R5: Port cycles are issued only for strobed lanes, in ascending lane order, with `pt_we` equal to `req_write`. A write with no strobes produces no port cycle.
- R6: In the indexed sub-window (0x500–0x515), halfword h of the word at offset A uses register index ((A − 0x500) >> 1) + h. Each halfword access starts with an index write (`rf_sel`=0, `rf_we`=1, `rf_wdata`=index). Its data cycle (`rf_sel`=1) is issued only after that index write is acknowledged.
- R7: An access strobing both halfwords becomes two register accesses, lower halfword (lanes 0–1) first. Read data returns in bits [15:0] and [31:16].
- R8: A write that strobes only one byte of a halfword performs index write, data read, then data write. The data write carries the new byte and keeps the other byte as read.
- R9: The upper halfword of the word at 0x514 (offset 0x516) is outside the array. It is never accessed and reads as zero.
- R10: `req_ready` stays low until every beat has been acknowledged and is high for exactly one cycle. A request stays stable until acknowledged. With back-ends that acknowledge one cycle after each request, the latency is 1 + 2 × (number of back-end cycles).
- R11: An indexed read returns all 16 bits of any halfword with at least one strobe set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_en | input | 1 | Window enable, sampled when an access is accepted |
| req_valid | input | 1 | Host access pending, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_waddr | input | 10 | Word address within the window (byte offset >> 2) |
| req_wdata | input | 32 | Write data, little-endian lanes |
| req_strb | input | 4 | Byte strobes, bit L selects lane L |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data, valid with `req_ready` |
| pt_req | output | 1 | Port cycle request, held until `pt_ack` |
| pt_we | output | 1 | Port cycle is a write |
| pt_addr | output | 16 | Port address |
| pt_wdata | output | 8 | Port write byte |
| pt_ack | input | 1 | Port cycle complete |
| pt_rdata | input | 8 | Port read byte, valid with `pt_ack` |
| rf_req | output | 1 | Register-file cycle request, held until `rf_ack` |
| rf_sel | output | 1 | 0 = index register, 1 = data register |
| rf_we | output | 1 | Register-file cycle is a write |
| rf_wdata | output | 16 | Index value or data halfword |
| rf_ack | input | 1 | Register-file cycle complete |
| rf_rdata | input | 16 | Data halfword, valid with `rf_ack` |

## Verification
The bench builds the bridge with its default parameters: a 12-bit window, a 32-byte port span based at port 0x3C0, and 11 indexed registers starting at offset 0x500. Because the register count is odd, the last register sits alone in the lower half of its word. This lets the bench reach the half-mapped word at 0x514, as well as the unmapped gap above it and the gap between the two sub-windows. Back-end models that acknowledge every request one cycle later make the beat count visible as latency. Logged back-end cycles expose the lane order, the index-before-data order and the read-modify-write sequence.

// File: rtl/mib_pkg.sv
// Shared constants and types for the flat-window bridge.
package mib_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int HALF_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PORT  = 3'd1,
        ST_INDEX = 3'd2,
        ST_RDATA = 3'd3,
        ST_WDATA = 3'd4,
        ST_DONE  = 3'd5
    } state_t;
endpackage

// File: rtl/mib_decode.sv
// Window decoder: classifies a word address as port sub-window, indexed
// sub-window or unmapped. It also gives the first register index and the
// port-relative offset. Assumes both sub-window bases are word aligned.
module mib_decode #(
    parameter int unsigned WIN_AW    = 12,
    parameter int unsigned PORT_BASE = 32'h400,
    parameter int unsigned PORT_SPAN = 32,
    parameter int unsigned IDX_BASE  = 32'h500,
    parameter int unsigned IDX_COUNT = 11,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned POFF_W    = 5
) (
    input  logic              en,
    input  logic [WIN_AW-3:0] waddr,
    output logic              is_port,
    output logic              is_idx,
    output logic [1:0]        half_ok,
    output logic [IDX_W-1:0]  idx0,
    output logic [POFF_W-1:0] port_off
);
    logic [31:0] base;

    // Byte offset of the addressed word and region classification.
    always_comb begin
        base     = {22'd0, waddr, 2'b00};
        is_port  = en && (base >= PORT_BASE) && (base < PORT_BASE + PORT_SPAN);
        is_idx   = en && (base >= IDX_BASE) && (base < IDX_BASE + 2 * IDX_COUNT);
        idx0     = IDX_W'((base - IDX_BASE) >> 1);
        port_off = POFF_W'(base - PORT_BASE);
    end

    // Each halfword of the word is mapped only if its index exists.
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half_ok[h] = is_idx &&
                            (((base + 2 * h - IDX_BASE) >> 1) < IDX_COUNT);
    end
endmodule

// File: rtl/mib_low_pick.sv
// Lowest-set-bit picker: position and one-hot of the lowest set bit of vec.
// Assumes nothing about vec; an all-zero vector yields position 0 and no bit.
module mib_low_pick #(
    parameter int N = 4,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] pos,
    output logic [N-1:0] onehot
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        pos    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                pos    = W'(i);
                onehot = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/mib_half_merge.sv
// Lane merger: per lane, takes new data where the strobe is set and keeps
// old data elsewhere. Used to build read-modify-write halfwords.
module mib_half_merge #(
    parameter int LANE_W = 8,
    parameter int N      = 2
) (
    input  logic [N*LANE_W-1:0] new_data,
    input  logic [N*LANE_W-1:0] old_data,
    input  logic [N-1:0]        strb,
    output logic [N*LANE_W-1:0] merged
);
    for (genvar l = 0; l < N; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = strb[l] ? new_data[l*LANE_W +: LANE_W]
                                                    : old_data[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/mmio_idx_bridge.sv
// Flat register window bridge. It decodes a host word access and:
//  - in the port sub-window, issues one byte port cycle per strobed lane,
//    lowest lane first;
//  - in the indexed sub-window, for each touched halfword (lower first),
//    writes the index, then reads and/or writes the data register, with
//    read-modify-write when only one byte of the halfword is strobed;
//  - otherwise, or with the window disabled, completes at once.
// Assumes the host holds its request stable until req_ready, and the
// back-ends hold no more than one cycle outstanding each.
module mmio_idx_bridge
    import mib_pkg::*;
#(
    parameter int unsigned WIN_AW       = 12,
    parameter int unsigned PORT_BASE    = 32'h400,
    parameter int unsigned PORT_SPAN    = 32,
    parameter int unsigned PIO_AW       = 16,
    parameter int unsigned PORT_IO_BASE = 32'h3C0,
    parameter int unsigned IDX_BASE     = 32'h500,
    parameter int unsigned IDX_COUNT    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [WIN_AW-3:0] req_waddr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_strb,
    output logic              req_ready,
    output logic [31:0]       rsp_rdata,
    output logic              pt_req,
    output logic              pt_we,
    output logic [PIO_AW-1:0] pt_addr,
    output logic [7:0]        pt_wdata,
    input  logic              pt_ack,
    input  logic [7:0]        pt_rdata,
    output logic              rf_req,
    output logic              rf_sel,
    output logic              rf_we,
    output logic [15:0]       rf_wdata,
    input  logic              rf_ack,
    input  logic [15:0]       rf_rdata
);
    localparam int unsigned IDX_W  = $clog2(IDX_COUNT + 1);
    localparam int unsigned POFF_W = $clog2(PORT_SPAN);

    state_t              st;
    logic                we_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    strb_q;
    logic [POFF_W-1:0]   poff_q;
    logic [IDX_W-1:0]    idx0_q;
    logic [LANES-1:0]    pend_q;
    logic [1:0]          hpend_q;
    logic [DATA_W-1:0]   rd_q;
    logic [HALF_W-1:0]   rmw_q;

    logic                dec_port, dec_idx;
    logic [1:0]          dec_half_ok;
    logic [IDX_W-1:0]    dec_idx0;
    logic [POFF_W-1:0]   dec_poff;
    logic [1:0]          hp_in;
    logic [1:0]          lane;
    logic [LANES-1:0]    lane_oh;
    logic                hc;
    logic [1:0]          hc_oh;
    logic [1:0]          half_strb;
    logic [HALF_W-1:0]   half_wd;
    logic [HALF_W-1:0]   merged;
    logic [IDX_W-1:0]    cur_idx;
    logic [LANES-1:0]    pend_rest;
    logic [1:0]          hpend_rest;

    mib_decode #(
        .WIN_AW(WIN_AW), .PORT_BASE(PORT_BASE), .PORT_SPAN(PORT_SPAN),
        .IDX_BASE(IDX_BASE), .IDX_COUNT(IDX_COUNT), .IDX_W(IDX_W), .POFF_W(POFF_W)
    ) u_dec (
        .en(win_en), .waddr(req_waddr), .is_port(dec_port), .is_idx(dec_idx),
        .half_ok(dec_half_ok), .idx0(dec_idx0), .port_off(dec_poff)
    );

    mib_low_pick #(.N(LANES)) u_lane_pick (.vec(pend_q), .pos(lane), .onehot(lane_oh));
    mib_low_pick #(.N(2))     u_half_pick (.vec(hpend_q), .pos(hc), .onehot(hc_oh));

    mib_half_merge #(.LANE_W(8), .N(2)) u_merge (
        .new_data(half_wd), .old_data(rmw_q), .strb(half_strb), .merged(merged)
    );

    // Per-beat selections derived from the pending masks.
    always_comb begin
        hp_in      = dec_half_ok & {|req_strb[3:2], |req_strb[1:0]};
        half_strb  = hc ? strb_q[3:2] : strb_q[1:0];
        half_wd    = hc ? wdata_q[31:16] : wdata_q[15:0];
        cur_idx    = IDX_W'(idx0_q + IDX_W'(hc));
        pend_rest  = pend_q & ~lane_oh;
        hpend_rest = hpend_q & ~hc_oh;
    end

    // Back-end and host outputs decoded from the state.
    always_comb begin
        pt_req    = (st == ST_PORT);
        pt_we     = we_q;
        pt_addr   = PIO_AW'(PORT_IO_BASE + 32'(poff_q) + 32'(lane));
        pt_wdata  = wdata_q[32'(lane) * 8 +: 8];
        rf_req    = (st == ST_INDEX) || (st == ST_RDATA) || (st == ST_WDATA);
        rf_sel    = (st != ST_INDEX);
        rf_we     = (st != ST_RDATA);
        rf_wdata  = (st == ST_INDEX) ? 16'(cur_idx) : merged;
        req_ready = (st == ST_DONE);
        rsp_rdata = rd_q;
    end

    // Sequencer: accept, walk the beats, collect read data, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            we_q    <= 1'b0;
            wdata_q <= '0;
            strb_q  <= '0;
            poff_q  <= '0;
            idx0_q  <= '0;
            pend_q  <= '0;
            hpend_q <= '0;
            rd_q    <= '0;
            rmw_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    we_q    <= req_write;
                    wdata_q <= req_wdata;
                    strb_q  <= req_strb;
                    poff_q  <= dec_poff;
                    idx0_q  <= dec_idx0;
                    rd_q    <= '0;
                    pend_q  <= dec_port ? req_strb : '0;
                    hpend_q <= hp_in;
                    if (dec_port && (|req_strb)) st <= ST_PORT;
                    else if (|hp_in)             st <= ST_INDEX;
                    else                         st <= ST_DONE;
                end
                ST_PORT: if (pt_ack) begin
                    if (!we_q) rd_q[32'(lane) * 8 +: 8] <= pt_rdata;
                    pend_q <= pend_rest;
                    if (pend_rest == '0) st <= ST_DONE;
                end
                ST_INDEX: if (rf_ack) begin
                    st <= (we_q && (&half_strb)) ? ST_WDATA : ST_RDATA;
                end
                ST_RDATA: if (rf_ack) begin
                    if (we_q) begin
                        rmw_q <= rf_rdata;
                        st    <= ST_WDATA;
                    end else begin
                        rd_q[32'(hc) * 16 +: 16] <= rf_rdata;
                        hpend_q <= hpend_rest;
                        st      <= (hpend_rest != '0) ? ST_INDEX : ST_DONE;
                    end
                end
                ST_WDATA: if (rf_ack) begin
                    hpend_q <= hpend_rest;
                    st      <= (hpend_rest != '0) ? ST_INDEX : ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mib_checker.sv
// Protocol checker for the bridge, bound to every instance. It tracks
// whether a host access is open, the enable seen when it opened, and whether
// the index write for the current halfword has been acknowledged.
module mib_checker #(
    parameter int unsigned PIO_AW       = 16,
    parameter int unsigned PORT_IO_BASE = 32'h3C0,
    parameter int unsigned PORT_SPAN    = 32,
    parameter int unsigned IDX_COUNT    = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic              pt_req,
    input logic [PIO_AW-1:0] pt_addr,
    input logic              pt_ack,
    input logic              rf_req,
    input logic              rf_sel,
    input logic              rf_we,
    input logic [15:0]       rf_wdata,
    input logic              rf_ack
);
    logic busy, en_q, idx_seen;

    // Open/close tracking of the host access and the enable at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            en_q <= 1'b0;
        end else if (req_ready) begin
            busy <= 1'b0;
        end else if (req_valid && !busy) begin
            busy <= 1'b1;
            en_q <= win_en;
        end
    end

    // Index-acknowledged flag: re-armed by each new index write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idx_seen <= 1'b0;
        else if (rf_req && !rf_sel) idx_seen <= rf_ack;
        else if (req_ready)         idx_seen <= 1'b0;
    end

    AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req |-> (32'(pt_addr) >= PORT_IO_BASE) &&
                   (32'(pt_addr) < PORT_IO_BASE + PORT_SPAN)); // R4
    AST_INDEX_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_sel) |-> idx_seen); // R6
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_sel) |-> (rf_we && (32'(rf_wdata) < IDX_COUNT))); // R6
    AST_ONE_BACKEND: assert property (@(posedge clk) disable iff (!rst_n)
        !(pt_req && rf_req)); // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en_q) |-> (!pt_req && !rf_req)); // R3
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R10
    AST_QUIET_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!pt_req && !rf_req)); // R10
    AST_PT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req && !pt_ack) |=> (pt_req && $stable(pt_addr))); // R10
    AST_RF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_ack) |=> (rf_req && $stable(rf_sel) && $stable(rf_we) &&
                                 $stable(rf_wdata))); // R10
endmodule

bind mmio_idx_bridge mib_checker #(
    .PIO_AW(PIO_AW), .PORT_IO_BASE(PORT_IO_BASE),
    .PORT_SPAN(PORT_SPAN), .IDX_COUNT(IDX_COUNT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .req_valid(req_valid),
    .req_ready(req_ready), .pt_req(pt_req), .pt_addr(pt_addr), .pt_ack(pt_ack),
    .rf_req(rf_req), .rf_sel(rf_sel), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rf_ack(rf_ack)
);

// File: tb/mmio_idx_bridge_tb.sv
`timescale 1ns/1ps
module mmio_idx_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_en = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_waddr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_strb = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic        pt_req, pt_we, pt_ack = 1'b0;
    logic [15:0] pt_addr;
    logic [7:0]  pt_wdata, pt_rdata = '0;
    logic        rf_req, rf_sel, rf_we, rf_ack = 1'b0;
    logic [15:0] rf_wdata, rf_rdata = '0;

    always #10 clk = ~clk;

    mmio_idx_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .win_en(win_en), .req_valid(req_valid),
        .req_write(req_write), .req_waddr(req_waddr), .req_wdata(req_wdata),
        .req_strb(req_strb), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .pt_req(pt_req), .pt_we(pt_we), .pt_addr(pt_addr), .pt_wdata(pt_wdata),
        .pt_ack(pt_ack), .pt_rdata(pt_rdata), .rf_req(rf_req), .rf_sel(rf_sel),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_ack(rf_ack), .rf_rdata(rf_rdata)
    );

    // Back-end models: acknowledge one cycle after each request, log it.
    logic [7:0]  port_mem [32];
    logic [15:0] regs [16];
    logic [3:0]  idx_m = '0;
    logic [15:0] pt_log [256];
    logic        rl_sel [256];
    logic        rl_we [256];
    logic [15:0] rl_wd [256];
    int pt_cnt = 0, rf_cnt = 0;

    always @(posedge clk) begin
        if (pt_req && !pt_ack) begin
            pt_ack <= 1'b1;
            pt_log[pt_cnt[7:0]] = pt_addr;
            pt_cnt++;
            if (pt_we) port_mem[pt_addr[4:0]] = pt_wdata;
            else       pt_rdata <= port_mem[pt_addr[4:0]];
        end else pt_ack <= 1'b0;
        if (rf_req && !rf_ack) begin
            rf_ack <= 1'b1;
            rl_sel[rf_cnt[7:0]] = rf_sel;
            rl_we[rf_cnt[7:0]]  = rf_we;
            rl_wd[rf_cnt[7:0]]  = rf_wdata;
            rf_cnt++;
            if (!rf_sel)    idx_m = rf_wdata[3:0];
            else if (rf_we) regs[idx_m] = rf_wdata;
            else            rf_rdata <= regs[idx_m];
        end else rf_ack <= 1'b0;
    end

    int n_chk = 0, n_err = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int pt0, rf0;
    task automatic access(input logic we, input logic [11:0] addr, input logic [3:0] strb,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        pt0 = pt_cnt; rf0 = rf_cnt;
        req_write = we; req_waddr = addr[11:2]; req_strb = strb; req_wdata = wd;
        req_valid = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!req_ready && lat < 200);
        if (!req_ready) check("R10 access timed out", 32'(lat), 32'd0);
        rd = rsp_rdata;
        req_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [3:0]  strb;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  npt;
        logic [3:0]  nrf;
    } vec_t;

    // Initial contents: port byte i = 0x40+i, register i = {0xC0+i, 0x30+i}.
    localparam vec_t TBL [15] = '{
        '{1'b0, 12'h400, 4'hF, 32'h0,        32'h43424140, 4'd4, 4'd0}, // R5 all lanes
        '{1'b0, 12'h41C, 4'h4, 32'h0,        32'h005E0000, 4'd1, 4'd0}, // R4 top of span
        '{1'b1, 12'h408, 4'h6, 32'h11223344, 32'h0,        4'd2, 4'd0}, // R4 middle lanes
        '{1'b0, 12'h408, 4'hF, 32'h0,        32'h4B223348, 4'd4, 4'd0}, // R4 readback
        '{1'b0, 12'h500, 4'hF, 32'h0,        32'hC131C030, 4'd0, 4'd4}, // R7 two halves
        '{1'b0, 12'h514, 4'hF, 32'h0,        32'h0000CA3A, 4'd0, 4'd2}, // R9 last register
        '{1'b1, 12'h504, 4'hF, 32'hBEEF1234, 32'h0,        4'd0, 4'd4}, // R7 wide write
        '{1'b0, 12'h504, 4'h1, 32'h0,        32'h00001234, 4'd0, 4'd2}, // R11 one-byte read
        '{1'b1, 12'h508, 4'h2, 32'h0000AB00, 32'h0,        4'd0, 4'd3}, // R8 high byte rmw
        '{1'b0, 12'h508, 4'h3, 32'h0,        32'h0000AB34, 4'd0, 4'd2}, // R8 kept low byte
        '{1'b0, 12'h300, 4'hF, 32'h0,        32'h0,        4'd0, 4'd0}, // R2 reserved
        '{1'b1, 12'h420, 4'hF, 32'hFFFFFFFF, 32'h0,        4'd0, 4'd0}, // R2 gap write
        '{1'b0, 12'h4F0, 4'hF, 32'h0,        32'h0,        4'd0, 4'd0}, // R2 gap read
        '{1'b0, 12'h518, 4'hF, 32'h0,        32'h0,        4'd0, 4'd0}, // R2 above array
        '{1'b0, 12'h504, 4'hF, 32'h0,        32'hBEEF1234, 4'd0, 4'd4}  // R7 wide readback
    };

    function automatic string tag_of(input int i);
        case (i)
            0:        return "R5";
            1, 2, 3:  return "R4";
            4, 6, 14: return "R7";
            5:        return "R9";
            7:        return "R11";
            8, 9:     return "R8";
            default:  return "R2";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int lat;
        for (int i = 0; i < 32; i++) port_mem[i] = 8'h40 + 8'(i);
        for (int i = 0; i < 16; i++) regs[i] = {8'hC0 + 8'(i), 8'h30 + 8'(i)};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready in reset", 32'(req_ready), 32'd0);
        check("R1 rdata in reset", rsp_rdata, 32'd0);
        check("R1 requests in reset", {30'd0, pt_req, rf_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 quiet after reset", {29'd0, req_ready, pt_req, rf_req}, 32'd0);

        // Vector table walk: data, beat counts and latency per access.
        for (int i = 0; i < 15; i++) begin
            access(TBL[i].we, TBL[i].addr, TBL[i].strb, TBL[i].wd, rd, lat);
            if (!TBL[i].we) check({tag_of(i), " read data"}, rd, TBL[i].exp);
            check({tag_of(i), " port cycles"}, 32'(pt_cnt - pt0), 32'(TBL[i].npt));
            check({tag_of(i), " register cycles"}, 32'(rf_cnt - rf0), 32'(TBL[i].nrf));
            check("R10 latency", 32'(lat),
                  32'(1 + 2 * (int'(TBL[i].npt) + int'(TBL[i].nrf))));
        end

        // R5: sparse strobes go out in ascending lane order.
        access(1'b0, 12'h40C, 4'hA, 32'h0, rd, lat);
        check("R5 sparse read data", rd, 32'h4F004D00);
        check("R5 first lane port", 32'(pt_log[pt0[7:0]]), 32'h3CD);
        check("R5 second lane port", 32'(pt_log[pt0[7:0] + 8'd1]), 32'h3CF);

        // R5: write without strobes does nothing.
        access(1'b1, 12'h404, 4'h0, 32'hFFFFFFFF, rd, lat);
        check("R5 empty write cycles", 32'(pt_cnt - pt0), 32'd0);
        check("R2 empty write latency", 32'(lat), 32'd1);

        // R6/R8: sequence of a partial write to the upper halfword.
        access(1'b1, 12'h50C, 4'h4, 32'h00770000, rd, lat);
        check("R6 cycle count", 32'(rf_cnt - rf0), 32'd3);
        check("R6 index first", {15'd0, rl_sel[rf0[7:0]], rl_we[rf0[7:0]], rl_wd[rf0[7:0]]},
              {15'd0, 1'b0, 1'b1, 16'd7});
        check("R8 data read second", {30'd0, rl_sel[rf0[7:0] + 8'd1], rl_we[rf0[7:0] + 8'd1]},
              32'b10);
        check("R8 merged write third",
              {15'd0, rl_sel[rf0[7:0] + 8'd2], rl_we[rf0[7:0] + 8'd2], rl_wd[rf0[7:0] + 8'd2]},
              {15'd0, 1'b1, 1'b1, 16'hC777});
        access(1'b0, 12'h50C, 4'hC, 32'h0, rd, lat);
        check("R8 readback upper half", rd, 32'hC7770000);

        // R7: lower halfword index issued before upper.
        access(1'b0, 12'h500, 4'hF, 32'h0, rd, lat);
        check("R7 first index", 32'(rl_wd[rf0[7:0]]), 32'd0);
        check("R7 second index", 32'(rl_wd[rf0[7:0] + 8'd2]), 32'd1);

        // R3: disabled window reaches nothing.
        win_en = 1'b0;
        access(1'b0, 12'h400, 4'hF, 32'h0, rd, lat);
        check("R3 disabled read data", rd, 32'd0);
        check("R3 disabled latency", 32'(lat), 32'd1);
        access(1'b1, 12'h500, 4'hF, 32'hDEADDEAD, rd, lat);
        check("R3 disabled cycles", 32'(pt_cnt - pt0 + rf_cnt - rf0), 32'd0);
        win_en = 1'b1;
        access(1'b0, 12'h500, 4'h3, 32'h0, rd, lat);
        check("R3 register unchanged", rd, 32'h0000C030);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule